// File: doc/BRIEF.md
# Configurable serial character receiver

This block recovers characters from a serial line and hands each one to a consumer together with its parity and framing status. It runs in one of two sampling modes. In asynchronous mode the line is oversampled: a falling edge on the idle-high line begins a character, the start bit is confirmed halfway through, and every later bit is taken at its centre, counted in ticks of an oversample enable supplied from outside. In synchronous slave mode the block follows an external serial clock and takes one bit on each selected edge of that clock, where the polarity control picks the rising or the falling edge.

The character format comes from two codes. One sets the length at seven, eight or nine data bits, sent least significant bit first. The other sets no parity, even parity or odd parity. A single stop bit is checked. A finished character is held on the output with its flags until the consumer accepts it, and the request-to-send output tells the far end whether the receiver can take another one. A loopback select feeds the receiver from the local transmit line in place of the pin, and it routes request-to-send back to the local transmitter as its clear-to-send. Clearing the enable returns the receiver to idle and drops any held character.

The controller has five states. ST_IDLE waits for a start. In asynchronous mode it goes to ST_START on a falling edge of the synchronized line. In synchronous mode it goes directly to ST_DATA when a low level is sampled on a sample edge. ST_START goes to ST_DATA if the line is still low at the start midpoint, and back to ST_IDLE if it is high. ST_DATA stays put until the last data bit, then goes to ST_PARITY when parity is on and to ST_STOP when it is off. ST_PARITY goes to ST_STOP after one bit. ST_STOP goes to ST_IDLE after the stop sample and delivers the character. A low enable forces ST_IDLE from any state.

Top module: `chr_rx`

## Requirements
- R1: Length code 0, 1 and 2 on `len_code` give 7, 8 and 9 data bits, and code 3 gives 8. Bits arrive least significant first and appear right-aligned in `rx_data`, with every unused upper bit zero.
- R2: Parity code 2 on `par_code` is even and code 3 is odd. Each adds one parity bit after the data, and `rx_perr` is set when the count of ones in data plus parity bit has the wrong oddness. Codes 0 and 1 mean the frame has no parity bit, and `rx_perr` stays 0.
- R3: Exactly one stop bit is sampled. If it is low, `rx_ferr` is set with the character, and the receiver returns to idle.
- R4: In asynchronous mode (`sync_mode`=0) the selected line goes through a two-flop synchronizer. A high-to-low transition starts a character, which is confirmed on the OS_RATE/2-th `os_tick` after that. If the line is high at that point, the start is dropped and nothing is delivered. Each following bit is sampled every OS_RATE ticks.
- R5: In synchronous mode (`sync_mode`=1) the line is sampled on edges of the synchronized `sclk`: falling edges when `sclk_rise`=0 and rising edges when `sclk_rise`=1. A low sample in idle is the start bit, and each later sample edge takes one bit.
- R6: With `loop_sel`=1 the receiver reads `txd_int` and ignores `rxd_pin`, and `cts_to_tx` equals `rts_out`. With `loop_sel`=0, `cts_to_tx` follows `cts_pin`.
- R7: While `en`=0 the receiver is held in idle with its counters cleared, a partly received character is discarded, and `rx_valid` is 0.
- R8: `rx_valid` rises on the clock edge that samples the stop bit. It stays high, with data and flags unchanged, until a clock edge where `rx_ack` is 1. A newer character replaces an unaccepted one.
- R9: `rts_out` is 1 exactly when `en` is 1 and no character is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Receiver enable; low resets the controller |
| sync_mode | input | 1 | 0 oversampled asynchronous, 1 synchronous slave |
| sclk_rise | input | 1 | Synchronous sample edge: 0 falling, 1 rising |
| os_tick | input | 1 | Oversample enable, OS_RATE per bit |
| sclk | input | 1 | External serial clock |
| rxd_pin | input | 1 | Serial input from the pin |
| txd_int | input | 1 | Local transmit line used in loopback |
| loop_sel | input | 1 | 1 selects loopback |
| len_code | input | 2 | Data length code |
| par_code | input | 2 | Parity code |
| rx_ack | input | 1 | Consumer accepts the held character |
| cts_pin | input | 1 | Clear-to-send from the pin |
| rx_data | output | 9 | Received character, right-aligned |
| rx_valid | output | 1 | A character is held |
| rx_perr | output | 1 | Parity error of held character |
| rx_ferr | output | 1 | Framing error of held character |
| rts_out | output | 1 | Request-to-send: ready for a character |
| cts_to_tx | output | 1 | Clear-to-send for the local transmitter |

## Verification
The bench builds the block with OS_RATE=8, so a bit spans eight ticks and a whole frame fits in about a hundred clocks. Many frames, with every length and parity code, can therefore run in a short test. For one frame the tick is gated to every second clock, which makes the tick counter, and not the clock, set the bit timing. A start glitch shorter than four ticks tests the midpoint check, and aborting a frame partway tests the enable reset. Both synchronous edge polarities are run with the clock edges spaced several clocks apart, so that the synchronizer latency is fully covered.

// File: rtl/chr_rx_pkg.sv
package chr_rx_pkg;

    localparam int CHR_W = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    function automatic logic [3:0] data_bits(input logic [1:0] code);
        unique case (code)
            2'd0:    data_bits = 4'd7;
            2'd2:    data_bits = 4'd9;
            default: data_bits = 4'd8;
        endcase
    endfunction

    function automatic logic parity_on(input logic [1:0] code);
        parity_on = code[1];
    endfunction

endpackage

// File: rtl/chr_rx_sync.sv
module chr_rx_sync #(
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q,
    output logic q_d
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= {STAGES{INIT}};
            q_d   <= INIT;
        end else begin
            chain <= {chain[STAGES-2:0], d};
            q_d   <= chain[STAGES-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/chr_rx_core.sv
module chr_rx_core
    import chr_rx_pkg::*;
#(
    parameter int OS_RATE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sync_mode,
    input  logic             os_tick,
    input  logic             samp_edge,
    input  logic             line,
    input  logic             line_fall,
    input  logic [1:0]       len_code,
    input  logic [1:0]       par_code,
    output logic             done,
    output logic [CHR_W-1:0] out_data,
    output logic             out_perr,
    output logic             out_ferr
);
    localparam int CW   = (OS_RATE > 2) ? $clog2(OS_RATE) : 1;
    localparam int MID  = OS_RATE / 2 - 1;
    localparam int LAST = OS_RATE - 1;

    rx_state_e        state, nxt;
    logic [CW-1:0]    cnt;
    logic [3:0]       bidx;
    logic [CHR_W-1:0] sh;
    logic             pbit;
    logic             step, due, last_bit;

    assign step     = sync_mode ? samp_edge : os_tick;
    assign due      = sync_mode | (cnt == CW'(LAST));
    assign last_bit = (bidx == data_bits(len_code) - 4'd1);

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (sync_mode) begin
                    if (step && !line) nxt = ST_DATA;
                end else if (line_fall) begin
                    nxt = ST_START;
                end
            end
            ST_START: begin
                if (sync_mode)                              nxt = ST_IDLE;
                else if (os_tick && cnt == CW'(MID))        nxt = line ? ST_IDLE : ST_DATA;
            end
            ST_DATA: begin
                if (step && due && last_bit)
                    nxt = parity_on(par_code) ? ST_PARITY : ST_STOP;
            end
            ST_PARITY: if (step && due) nxt = ST_STOP;
            ST_STOP:   if (step && due) nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
        if (!en) nxt = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            bidx <= '0;
            sh   <= '0;
            pbit <= 1'b0;
        end else if (!en) begin
            cnt  <= '0;
            bidx <= '0;
            sh   <= '0;
            pbit <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    cnt  <= '0;
                    bidx <= '0;
                    sh   <= '0;
                    pbit <= 1'b0;
                end
                ST_START: begin
                    if (os_tick) cnt <= (cnt == CW'(MID)) ? '0 : cnt + CW'(1);
                end
                default: begin
                    if (step) begin
                        if (due) begin
                            cnt <= '0;
                            if (state == ST_DATA) begin
                                for (int i = 0; i < CHR_W; i++)
                                    if (bidx == 4'(i)) sh[i] <= line;
                                bidx <= bidx + 4'd1;
                            end
                            if (state == ST_PARITY) pbit <= line;
                        end else begin
                            cnt <= cnt + CW'(1);
                        end
                    end
                end
            endcase
        end
    end

    assign done     = en && (state == ST_STOP) && step && due;
    assign out_data = sh;
    assign out_ferr = ~line;
    assign out_perr = parity_on(par_code) & (^sh ^ pbit ^ par_code[0]);
endmodule

// File: rtl/chr_rx_hold.sv
module chr_rx_hold
    import chr_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic [CHR_W-1:0] d_data,
    input  logic             d_perr,
    input  logic             d_ferr,
    input  logic             ack,
    output logic             q_valid,
    output logic [CHR_W-1:0] q_data,
    output logic             q_perr,
    output logic             q_ferr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_data  <= '0;
            q_perr  <= 1'b0;
            q_ferr  <= 1'b0;
        end else if (!en) begin
            q_valid <= 1'b0;
        end else if (load) begin
            q_valid <= 1'b1;
            q_data  <= d_data;
            q_perr  <= d_perr;
            q_ferr  <= d_ferr;
        end else if (ack && q_valid) begin
            q_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/chr_rx.sv
module chr_rx
    import chr_rx_pkg::*;
#(
    parameter int OS_RATE     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sync_mode,
    input  logic             sclk_rise,
    input  logic             os_tick,
    input  logic             sclk,
    input  logic             rxd_pin,
    input  logic             txd_int,
    input  logic             loop_sel,
    input  logic [1:0]       len_code,
    input  logic [1:0]       par_code,
    input  logic             rx_ack,
    input  logic             cts_pin,
    output logic [CHR_W-1:0] rx_data,
    output logic             rx_valid,
    output logic             rx_perr,
    output logic             rx_ferr,
    output logic             rts_out,
    output logic             cts_to_tx
);
    localparam int NSYNC = 2;

    logic [NSYNC-1:0] raw_in, s_now, s_prev;
    logic             line_fall, samp_edge;
    logic             core_done, core_perr, core_ferr;
    logic [CHR_W-1:0] core_data;

    assign raw_in = {sclk, (loop_sel ? txd_int : rxd_pin)};

    for (genvar g = 0; g < NSYNC; g++) begin : g_sync
        chr_rx_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
            .clk(clk), .rst_n(rst_n), .d(raw_in[g]), .q(s_now[g]), .q_d(s_prev[g])
        );
    end

    assign line_fall = s_prev[0] & ~s_now[0];
    assign samp_edge = sclk_rise ? (s_now[1] & ~s_prev[1]) : (~s_now[1] & s_prev[1]);

    chr_rx_core #(.OS_RATE(OS_RATE)) u_core (
        .clk(clk), .rst_n(rst_n), .en(en), .sync_mode(sync_mode), .os_tick(os_tick),
        .samp_edge(samp_edge), .line(s_now[0]), .line_fall(line_fall),
        .len_code(len_code), .par_code(par_code), .done(core_done),
        .out_data(core_data), .out_perr(core_perr), .out_ferr(core_ferr)
    );

    chr_rx_hold u_hold (
        .clk(clk), .rst_n(rst_n), .en(en), .load(core_done), .d_data(core_data),
        .d_perr(core_perr), .d_ferr(core_ferr), .ack(rx_ack),
        .q_valid(rx_valid), .q_data(rx_data), .q_perr(rx_perr), .q_ferr(rx_ferr)
    );

    assign rts_out   = en & ~rx_valid;
    assign cts_to_tx = loop_sel ? rts_out : cts_pin;
endmodule

// File: rtl/chr_rx_check.sv
module chr_rx_check (
    input logic       clk,
    input logic       rst_n,
    input logic       en,
    input logic       rx_ack,
    input logic       rx_valid,
    input logic [8:0] rx_data,
    input logic       rx_perr,
    input logic       done,
    input logic [1:0] len_code,
    input logic       par_on
);
    a_r7_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !rx_valid);

    a_r8_valid_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_valid);

    a_r8_held_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && en && !rx_ack |=> rx_valid);

    a_r8_held_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid && en && !done |=> $stable(rx_data));

    a_r1_seven_bit_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        done && len_code == 2'd0 |=> rx_data[8:7] == 2'b00);

    a_r2_no_perr_without_parity: assert property (@(posedge clk) disable iff (!rst_n)
        done && !par_on |=> !rx_perr);
endmodule

bind chr_rx chr_rx_check u_chk (
    .clk(clk), .rst_n(rst_n), .en(en), .rx_ack(rx_ack), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_perr(rx_perr), .done(core_done),
    .len_code(len_code), .par_on(par_code[1])
);

// File: tb/chr_rx_test.sv
module chr_rx_test;
    localparam int OS = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, sync_mode = 1'b0, sclk_rise = 1'b0, sclk = 1'b0;
    logic rxd_pin = 1'b1, txd_int = 1'b1, loop_sel = 1'b0, rx_ack = 1'b0, cts_pin = 1'b0;
    logic [1:0] len_code = 2'd1, par_code = 2'd0;
    logic tick_half = 1'b0, tgl = 1'b0;
    logic os_tick;
    logic [8:0] rx_data;
    logic rx_valid, rx_perr, rx_ferr, rts_out, cts_to_tx;

    int nchk = 0, nfail = 0;
    bit cmp_on = 0;

    always #5 clk = ~clk;
    always @(negedge clk) tgl <= ~tgl;
    assign os_tick = !tick_half || tgl;

    chr_rx #(.OS_RATE(OS), .SYNC_STAGES(2)) uut (
        .clk(clk), .rst_n(rst_n), .en(en), .sync_mode(sync_mode), .sclk_rise(sclk_rise),
        .os_tick(os_tick), .sclk(sclk), .rxd_pin(rxd_pin), .txd_int(txd_int),
        .loop_sel(loop_sel), .len_code(len_code), .par_code(par_code), .rx_ack(rx_ack),
        .cts_pin(cts_pin), .rx_data(rx_data), .rx_valid(rx_valid), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rts_out(rts_out), .cts_to_tx(cts_to_tx)
    );

    task automatic chk(input string req, input int act, input int exp_v);
        nchk++;
        if (act !== exp_v) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // behavioural reference: line history queues and an integer phase counter
    int lq[$] = '{1, 1, 1, 1};
    int cq[$] = '{1, 1, 1, 1};
    int m_ph = 0, m_cnt = 0, m_bi = 0, m_pb = 0;
    int m_bits[9];
    int m_valid = 0, m_data = 0, m_perr = 0, m_ferr = 0;

    always @(posedge clk) begin
        int ln, lp, c2, cp, stp, due, nb, ones, fin;
        if (!rst_n) begin
            lq = '{1, 1, 1, 1};
            cq = '{1, 1, 1, 1};
            m_ph = 0; m_cnt = 0; m_bi = 0; m_pb = 0; m_valid = 0;
            m_data = 0; m_perr = 0; m_ferr = 0;
            foreach (m_bits[i]) m_bits[i] = 0;
        end else begin
            lq.push_front(loop_sel ? int'(txd_int) : int'(rxd_pin));
            lq = lq[0:3];
            cq.push_front(int'(sclk));
            cq = cq[0:3];
            ln = lq[2]; lp = lq[3]; c2 = cq[2]; cp = cq[3];
            stp = sync_mode ? (sclk_rise ? int'(c2 == 1 && cp == 0) : int'(c2 == 0 && cp == 1))
                            : int'(os_tick);
            nb = (len_code == 2'd0) ? 7 : (len_code == 2'd2) ? 9 : 8;
            fin = 0;
            if (!en) begin
                m_ph = 0; m_cnt = 0; m_bi = 0; m_pb = 0; m_valid = 0;
                foreach (m_bits[i]) m_bits[i] = 0;
            end else begin
                due = (sync_mode || m_cnt == OS - 1) ? 1 : 0;
                case (m_ph)
                    0: begin
                        m_cnt = 0; m_bi = 0; m_pb = 0;
                        foreach (m_bits[i]) m_bits[i] = 0;
                        if (sync_mode) begin
                            if (stp != 0 && ln == 0) m_ph = 2;
                        end else if (lp == 1 && ln == 0) m_ph = 1;
                    end
                    1: begin
                        if (sync_mode) m_ph = 0;
                        else if (os_tick) begin
                            if (m_cnt == OS / 2 - 1) begin
                                m_cnt = 0;
                                m_ph = (ln == 1) ? 0 : 2;
                            end else m_cnt++;
                        end
                    end
                    2: if (stp != 0) begin
                        if (due != 0) begin
                            m_bits[m_bi] = ln; m_bi++; m_cnt = 0;
                            if (m_bi == nb) m_ph = par_code[1] ? 3 : 4;
                        end else m_cnt++;
                    end
                    3: if (stp != 0) begin
                        if (due != 0) begin m_pb = ln; m_cnt = 0; m_ph = 4; end
                        else m_cnt++;
                    end
                    default: if (stp != 0) begin
                        if (due != 0) begin fin = 1; m_cnt = 0; m_ph = 0; end
                        else m_cnt++;
                    end
                endcase
                if (fin != 0) begin
                    m_data = 0; ones = 0;
                    foreach (m_bits[i]) begin
                        m_data += m_bits[i] << i;
                        ones += m_bits[i];
                    end
                    m_ferr = (ln == 0) ? 1 : 0;
                    m_perr = (par_code[1] && ((ones + m_pb) % 2 != int'(par_code == 2'd3))) ? 1 : 0;
                    m_valid = 1;
                end else if (rx_ack && m_valid != 0) m_valid = 0;
            end
        end
    end

    // per-clock comparison against the reference
    always @(posedge clk) begin
        int exp_rts;
        #2;
        if (rst_n && cmp_on) begin
            exp_rts = (en && m_valid == 0) ? 1 : 0;
            chk("R8 valid vs model", int'(rx_valid), m_valid);
            chk("R9 rts vs model", int'(rts_out), exp_rts);
            chk("R6 cts vs model", int'(cts_to_tx), loop_sel ? exp_rts : int'(cts_pin));
            if (m_valid != 0) begin
                chk("R1 data vs model", int'(rx_data), m_data);
                chk("R2 perr vs model", int'(rx_perr), m_perr);
                chk("R3 ferr vs model", int'(rx_ferr), m_ferr);
            end
        end
    end

    task automatic set_line(input logic b);
        if (loop_sel) txd_int = b; else rxd_pin = b;
    endtask

    task automatic build(input int val, input int nb, input int par, input bit flip,
                         input bit stop_v, output int bits[$]);
        int ones = 0;
        bits = {};
        bits.push_back(0);
        for (int i = 0; i < nb; i++) begin
            bits.push_back((val >> i) & 1);
            ones += (val >> i) & 1;
        end
        if (par >= 2) bits.push_back(((ones % 2) ^ (par == 3 ? 1 : 0) ^ int'(flip)) & 1);
        bits.push_back(int'(stop_v));
    endtask

    task automatic send_async(input int val, input int nb, input int par, input bit flip,
                              input bit stop_v);
        int bits[$];
        int per = tick_half ? 2 * OS : OS;
        build(val, nb, par, flip, stop_v, bits);
        foreach (bits[i]) begin
            @(negedge clk) set_line(bits[i][0]);
            repeat (per - 1) @(negedge clk);
        end
        @(negedge clk) set_line(1'b1);
        repeat (2 * per) @(negedge clk);
    endtask

    task automatic send_sync(input int val, input int nb, input int par, input bit flip);
        int bits[$];
        build(val, nb, par, flip, 1'b1, bits);
        foreach (bits[i]) begin
            @(negedge clk) rxd_pin = bits[i][0];
            repeat (3) @(negedge clk);
            sclk = sclk_rise;
            repeat (3) @(negedge clk);
            sclk = ~sclk_rise;
        end
        @(negedge clk) rxd_pin = 1'b1;
        repeat (6) @(negedge clk);
    endtask

    task automatic take(input string req, input int exp_d, input int exp_p, input int exp_f);
        chk(req, int'(rx_valid), 1);
        chk(req, int'(rx_data), exp_d);
        chk(req, int'(rx_perr), exp_p);
        chk(req, int'(rx_ferr), exp_f);
        @(negedge clk) rx_ack = 1'b1;
        @(negedge clk) rx_ack = 1'b0;
        chk(req, int'(rx_valid), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL R8 watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk) en = 1'b1;
        cmp_on = 1;
        @(negedge clk);
        chk("R9 reset rts", int'(rts_out), 1);
        chk("R8 reset valid", int'(rx_valid), 0);

        // R1: lengths
        send_async(9'h0A5, 8, 0, 0, 1);
        take("R1 8-bit", 'h0A5, 0, 0);
        len_code = 2'd0;
        send_async(9'h0FF, 7, 0, 0, 1);
        take("R1 7-bit", 'h07F, 0, 0);
        len_code = 2'd3;
        send_async(9'h03C, 8, 0, 0, 1);
        take("R1 code3 8-bit", 'h03C, 0, 0);

        // R2: parity
        len_code = 2'd2; par_code = 2'd2;
        send_async(9'h1C3, 9, 2, 0, 1);
        take("R2 even good", 'h1C3, 0, 0);
        send_async(9'h1C3, 9, 2, 1, 1);
        take("R2 even bad", 'h1C3, 1, 0);
        len_code = 2'd1; par_code = 2'd3;
        send_async(9'h081, 8, 3, 0, 1);
        take("R2 odd good", 'h081, 0, 0);
        send_async(9'h081, 8, 3, 1, 1);
        take("R2 odd bad", 'h081, 1, 0);
        par_code = 2'd1;
        send_async(9'h055, 8, 0, 0, 1);
        take("R2 code1 none", 'h055, 0, 0);

        // R3: framing
        par_code = 2'd0;
        send_async(9'h033, 8, 0, 0, 0);
        take("R3 low stop", 'h033, 0, 1);
        send_async(9'h0C4, 8, 0, 0, 1);
        take("R3 recovers", 'h0C4, 0, 0);

        // R4: false start and slowed tick
        @(negedge clk) rxd_pin = 1'b0;
        repeat (2) @(negedge clk);
        rxd_pin = 1'b1;
        repeat (3 * OS) @(negedge clk);
        chk("R4 glitch ignored", int'(rx_valid), 0);
        tick_half = 1'b1;
        send_async(9'h0E7, 8, 0, 0, 1);
        take("R4 half-rate tick", 'h0E7, 0, 0);
        tick_half = 1'b0;

        // R8 / R9: holding and overwrite
        send_async(9'h012, 8, 0, 0, 1);
        chk("R9 rts low while held", int'(rts_out), 0);
        repeat (5) @(negedge clk);
        chk("R8 still held", int'(rx_valid), 1);
        chk("R8 data stable", int'(rx_data), 'h012);
        send_async(9'h034, 8, 0, 0, 1);
        take("R8 overwrite", 'h034, 0, 0);
        chk("R9 rts back", int'(rts_out), 1);

        // R6: loopback
        @(negedge clk) txd_int = 1'b1;
        @(negedge clk) loop_sel = 1'b1;
        rxd_pin = 1'b0;
        repeat (4) @(negedge clk);
        chk("R6 cts from rts", int'(cts_to_tx), 1);
        send_async(9'h0B2, 8, 0, 0, 1);
        take("R6 loop data", 'h0B2, 0, 0);
        @(negedge clk) rxd_pin = 1'b1;
        repeat (4) @(negedge clk);
        loop_sel = 1'b0;
        repeat (4) @(negedge clk);
        chk("R6 cts from pin 0", int'(cts_to_tx), 0);
        cts_pin = 1'b1;
        @(negedge clk);
        chk("R6 cts from pin 1", int'(cts_to_tx), 1);
        cts_pin = 1'b0;

        // R7: enable reset mid-frame and while held
        @(negedge clk) rxd_pin = 1'b0;
        repeat (3 * OS) @(negedge clk);
        en = 1'b0;
        rxd_pin = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 rts low disabled", int'(rts_out), 0);
        en = 1'b1;
        repeat (12 * OS) @(negedge clk);
        chk("R7 partial discarded", int'(rx_valid), 0);
        send_async(9'h06D, 8, 0, 0, 1);
        chk("R7 held before disable", int'(rx_valid), 1);
        @(negedge clk) en = 1'b0;
        @(negedge clk) en = 1'b1;
        @(negedge clk);
        chk("R7 held dropped", int'(rx_valid), 0);
        send_async(9'h0A9, 8, 0, 0, 1);
        take("R7 after re-enable", 'h0A9, 0, 0);

        // R5: synchronous slave, both edges
        sync_mode = 1'b1;
        sclk_rise = 1'b1;
        sclk = 1'b0;
        repeat (6) @(negedge clk);
        send_sync(9'h05A, 8, 0, 0);
        take("R5 rising edge", 'h05A, 0, 0);
        par_code = 2'd2; len_code = 2'd2;
        send_sync(9'h123, 9, 2, 0);
        take("R5 rising 9-bit even", 'h123, 0, 0);
        par_code = 2'd0; len_code = 2'd1;
        sclk_rise = 1'b0;
        sclk = 1'b1;
        repeat (6) @(negedge clk);
        send_sync(9'h0C6, 8, 0, 0);
        take("R5 falling edge", 'h0C6, 0, 0);

        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule